// File: doc/BRIEF.md
# Ping-Pong Scanline Pixel Buffer

This block stores the colour indices of two scanlines for a tile or sprite renderer. It has four banks. Banks 1 and 2 hold the even and odd pixels of one line buffer, and banks 3 and 4 hold the even and odd pixels of the other. While the renderer fills one buffer, the other buffer is read out to the display. A complementary select pair swaps the two roles at the start of every scanline.

Each bank has three controls of its own: a strobe, a write qualifier and a pointer-mode control. On every strobe the bank touches one location and then leaves its pointer one past that location. The location is either the pointer's current value or a value loaded from the shared position bus. An opaque pixel is a strobe with the write qualifier, and it stores the pixel. A transparent pixel is a strobe without the write qualifier, and it only advances the pointer. A pixel removed by horizontal scaling gets no strobe, so nothing changes. On the displayed buffer, a strobe reads the location onto the output one cycle later. If the write qualifier is also present, the same strobe clears that location to the backdrop index, ready for the next render pass.

Top module: `scanline_pingpong_buf`

## Requirements
- R1: After reset every location of all four banks holds BACKDROP (default 0), every pointer is 0, and `out_vld` is low.
- R2: The select pair must be complementary. When `sel_a`=1 and `sel_b`=0, banks 1 and 2 (strobe bits 0 and 1) are filled and banks 3 and 4 (bits 2 and 3) are displayed. When `sel_a`=0 and `sel_b`=1, the roles are reversed.
- R3: A strobe whose `bank_inc` bit is 0 accesses the location given by `pos`, and afterwards the bank pointer holds `pos`+1.
- R4: A strobe whose `bank_inc` bit is 1 accesses the location at the current pointer, and afterwards the pointer is one higher.
- R5: On a filling bank, a strobe with its `bank_wr` bit high stores `even_pix` (banks 1 and 3) or `odd_pix` (banks 2 and 4) at the accessed location.
- R6: On a filling bank, a strobe with `bank_wr` low leaves the location unchanged but still advances the pointer. A cycle with no strobe changes neither the location nor the pointer.
- R7: A strobe on a displayed bank makes `out_vld` high in the next cycle, with `out_pix` equal to the value the accessed location held before the strobe. At most one displayed bank is strobed per cycle.
- R8: On a displayed bank, a strobe with `bank_wr` high writes BACKDROP to the location after reading it. With `bank_wr` low, the location keeps its value.
- R9: While `hblank` is high, all strobes are ignored: no write, no pointer change and no output.
- R10: An access at a location of 192 or above writes nothing and reads back as BACKDROP. The pointer still advances.
- R11: Filling one buffer and reading out the other in the same cycle do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hblank | input | 1 | Horizontal blanking; masks every strobe |
| sel_a | input | 1 | Role select; 1 means banks 1 and 2 are filled |
| sel_b | input | 1 | Complement of `sel_a` |
| bank_clk | input | 4 | Per-bank access strobe |
| bank_wr | input | 4 | Per-bank write qualifier |
| bank_inc | input | 4 | Per-bank pointer mode: 1 increments, 0 loads from `pos` |
| pos | input | 8 | Position bus (bank location) |
| even_pix | input | 8 | Colour index for even banks |
| odd_pix | input | 8 | Colour index for odd banks |
| out_pix | output | 8 | Colour index read from the displayed buffer |
| out_vld | output | 1 | `out_pix` holds a readout result |

## Verification
Filling one buffer and reading out the other are the two functions that share a cycle, because both are strobed at the same edge. The bench strobes a fill pair and a readout bank together for whole lines, with the readout clearing as it goes. Every readout value is compared against a model of all four banks. The next line, read back after the swap, shows whether a fill write, a clear write or a pointer move landed on the wrong buffer.

// File: rtl/scanline_pingpong_buf.sv
module scanline_pingpong_buf #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 192,
  parameter int PTR_W = 8,
  parameter logic [PIX_W-1:0] BACKDROP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hblank,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic [3:0]       bank_clk,
  input  logic [3:0]       bank_wr,
  input  logic [3:0]       bank_inc,
  input  logic [PTR_W-1:0] pos,
  input  logic [PIX_W-1:0] even_pix,
  input  logic [PIX_W-1:0] odd_pix,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_vld
);
  localparam int NB = 4;
  localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(DEPTH);

  logic [NB-1:0]    hit_v;
  logic [PIX_W-1:0] val_v [NB];

  for (genvar i = 0; i < NB; i++) begin : g_bank
    localparam bit UPPER = (i >= 2);
    localparam bit ODD   = (i % 2) == 1;

    logic [PTR_W-1:0] ptr, addr;
    logic [PIX_W-1:0] mem [DEPTH];
    logic [PIX_W-1:0] rd, wdat;
    logic             hit, stb, show, in_rng;

    assign stb    = bank_clk[i] & ~hblank;
    assign show   = UPPER ? (sel_a & ~sel_b) : (~sel_a & sel_b);
    assign addr   = bank_inc[i] ? ptr : pos;
    assign in_rng = {1'b0, addr} < LIMIT;
    assign wdat   = show ? BACKDROP : (ODD ? odd_pix : even_pix);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr <= '0;
        hit <= 1'b0;
        rd  <= BACKDROP;
        for (int k = 0; k < DEPTH; k++) mem[k[PTR_W-1:0]] <= BACKDROP;
      end else begin
        hit <= stb & show;
        if (stb) begin
          ptr <= addr + PTR_W'(1);
          rd  <= in_rng ? mem[addr] : BACKDROP;
          if (bank_wr[i] && in_rng) mem[addr] <= wdat;
        end
      end
    end

    assign hit_v[i] = hit;
    assign val_v[i] = rd;
  end

  always_comb begin
    out_vld = |hit_v;
    out_pix = BACKDROP;
    for (int i = NB - 1; i >= 0; i--)
      if (hit_v[i]) out_pix = val_v[i];
  end
endmodule

module scanline_pingpong_buf_chk #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 192,
  parameter int PTR_W = 8,
  parameter logic [PIX_W-1:0] BACKDROP = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hblank,
  input logic             sel_a,
  input logic             sel_b,
  input logic [3:0]       bank_clk,
  input logic [3:0]       bank_wr,
  input logic [3:0]       bank_inc,
  input logic [PTR_W-1:0] pos,
  input logic [PIX_W-1:0] out_pix,
  input logic             out_vld
);
  localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(DEPTH);
  logic [3:0] dmask;
  logic       dstb, dfar;
  assign dmask = sel_a ? 4'b1100 : 4'b0011;
  assign dstb  = !hblank && ((bank_clk & dmask) != 4'b0000);
  assign dfar  = dstb && ((bank_clk & dmask & ~bank_inc) != 4'b0000) && ({1'b0, pos} >= LIMIT);

  AST_SEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n) sel_a != sel_b); // R2
  AST_ONE_READER: assert property (@(posedge clk) disable iff (!rst_n) !hblank |-> $countones(bank_clk & dmask) <= 1); // R7
  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) out_vld |-> $past(dstb)); // R7
  AST_BLANK_SILENT: assert property (@(posedge clk) disable iff (!rst_n) $past(hblank) |-> !out_vld); // R9
  AST_FAR_BACKDROP: assert property (@(posedge clk) disable iff (!rst_n) $past(dfar) |-> out_pix == BACKDROP); // R10
endmodule

bind scanline_pingpong_buf scanline_pingpong_buf_chk #(
  .PIX_W(PIX_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .BACKDROP(BACKDROP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hblank(hblank), .sel_a(sel_a), .sel_b(sel_b),
  .bank_clk(bank_clk), .bank_wr(bank_wr), .bank_inc(bank_inc), .pos(pos),
  .out_pix(out_pix), .out_vld(out_vld)
);

// File: tb/scanline_pingpong_buf_test.sv
module scanline_pingpong_buf_test;
  logic clk = 1'b0, rst_n = 1'b0, hblank = 1'b0, sel_a = 1'b1, sel_b = 1'b0;
  logic [3:0] bclk = '0, bwr = '0, binc = '0;
  logic [7:0] pos = '0, ev = '0, od = '0;
  logic [7:0] out_pix;
  logic       out_vld;

  scanline_pingpong_buf uut (
    .clk(clk), .rst_n(rst_n), .hblank(hblank), .sel_a(sel_a), .sel_b(sel_b),
    .bank_clk(bclk), .bank_wr(bwr), .bank_inc(binc), .pos(pos),
    .even_pix(ev), .odd_pix(od), .out_pix(out_pix), .out_vld(out_vld)
  );

  always #5 clk = ~clk;

  logic [7:0] mdl [4][192];
  logic [7:0] mptr [4];
  logic [7:0] exp_q [$];
  int         tag_q [$];
  int checks = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input int tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // driver: one cycle of strobes, model updated from the requirements
  task automatic cyc(input logic [3:0] c, w, inc, input logic [7:0] p, e, o, input int tag);
    bclk = c; bwr = w; binc = inc; pos = p; ev = e; od = o;
    for (int b = 0; b < 4; b++) begin
      if (c[b] && !hblank) begin
        logic [7:0] a;
        bit sh;
        a  = inc[b] ? mptr[b] : p;                       // R3 R4
        sh = (b >= 2) ? sel_a : !sel_a;                  // R2
        if (sh) begin
          exp_q.push_back((a < 8'd192) ? mdl[b][a] : 8'h00); // R7 R10
          tag_q.push_back(tag);
        end
        if (w[b] && a < 8'd192) mdl[b][a] = sh ? 8'h00 : ((b % 2 == 0) ? e : o); // R5 R8
        mptr[b] = a + 8'd1;
      end
    end
    @(negedge clk);
    bclk = '0; bwr = '0; binc = '0;
  endtask

  // readout of the displayed buffer and/or fill of the other one, same cycles (R11)
  task automatic line(input int n, input bit rd, input bit clr, input bit fill,
                      input logic [7:0] fpos, input logic [7:0] seed, input int tag);
    for (int j = 0; j < n; j++) begin
      logic [3:0] c, w, inc;
      int db, fb;
      c = '0; w = '0; inc = '0;
      if (rd) begin
        db = (sel_a ? 2 : 0) + (j % 2);
        c[db] = 1'b1; w[db] = clr; inc[db] = (j >= 2);
      end
      if (fill && j >= 2) begin
        fb = sel_a ? 0 : 2;
        c[fb] = 1'b1; c[fb+1] = 1'b1; w[fb] = 1'b1; w[fb+1] = 1'b1;
        inc[fb] = (j > 2); inc[fb+1] = (j > 2);
      end
      cyc(c, w, inc, (j < 2) ? 8'h00 : fpos, seed + 8'(j), seed + 8'h80 + 8'(j), tag);
    end
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n && out_vld && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R7: pixel %0h expected no output", out_pix);
      end else begin
        logic [7:0] e;
        int t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_pix !== e) begin
          bad++;
          $display("FAIL R%0d: pixel %0h expected %0h", t, out_pix, e);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++; bad++;
      $display("FAIL R7: watchdog actual hung expected finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) begin
      mptr[b] = 8'h00;
      for (int a = 0; a < 192; a++) mdl[b][a] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == 1'b0, 1, int'(out_vld), 0);             // R1

    // R1 R11: read reset contents of 3/4 with clear while filling 1/2 from 0
    line(18, 1'b1, 1'b1, 1'b1, 8'd0, 8'h10, 11);
    // R6: bank 2 transparent, bank 1 opaque, then a skipped cycle
    cyc(4'b0011, 4'b0001, 4'b0011, 8'h00, 8'h55, 8'h66, 6);
    @(negedge clk);
    cyc(4'b0011, 4'b0011, 4'b0011, 8'h00, 8'h77, 8'h88, 6);

    // swap: read 1/2 with clear (R5 R6 values), fill 3/4 loading at 5 (R3 R4)
    sel_a = 1'b0; sel_b = 1'b1;
    line(40, 1'b1, 1'b1, 1'b1, 8'd5, 8'h20, 6);

    // R9: strobes during blanking do nothing
    hblank = 1'b1;
    cyc(4'b0001, 4'b0001, 4'b0000, 8'd3, 8'h00, 8'h00, 9);
    chk(out_vld == 1'b0, 9, int'(out_vld), 0);
    cyc(4'b1100, 4'b1100, 4'b0000, 8'd0, 8'hEE, 8'hEF, 9);
    hblank = 1'b0;

    // swap: read 3/4 without clear, then again (R8 keep), R3 load at 0
    sel_a = 1'b1; sel_b = 1'b0;
    line(44, 1'b1, 1'b0, 1'b0, 8'd0, 8'h00, 3);
    line(8, 1'b1, 1'b0, 1'b0, 8'd0, 8'h00, 8);
    // 1/2 were cleared by the earlier readout: R8
    sel_a = 1'b0; sel_b = 1'b1;
    line(8, 1'b1, 1'b0, 1'b0, 8'd0, 8'h00, 8);

    // R10: fill 3/4 at 190,191 and 192 (dropped)
    cyc(4'b1100, 4'b1100, 4'b0000, 8'd190, 8'hA1, 8'hB1, 10);
    cyc(4'b1100, 4'b1100, 4'b1100, 8'd0, 8'hA2, 8'hB2, 10);
    cyc(4'b1100, 4'b1100, 4'b1100, 8'd0, 8'hA3, 8'hB3, 10);
    sel_a = 1'b1; sel_b = 1'b0;
    cyc(4'b0100, 4'b0000, 4'b0000, 8'd190, 8'h00, 8'h00, 10);
    cyc(4'b1000, 4'b0000, 4'b0000, 8'd190, 8'h00, 8'h00, 10);
    for (int k = 0; k < 4; k++)
      cyc((k % 2 == 0) ? 4'b0100 : 4'b1000, 4'b0000, 4'b1100, 8'd0, 8'h00, 8'h00, 10);
    cyc(4'b0100, 4'b0000, 4'b0000, 8'd200, 8'h00, 8'h00, 10);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, 7, exp_q.size(), 0);           // R7 every readout appeared
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule